// File: doc/BRIEF.md
# Programmable Interval Timer

This block holds three independent 16-bit down-counting timer channels. A CPU reaches them over a byte-wide bus with chip select, read and write strobes, and a 2-bit address. Address 3 is the control register. Addresses 0, 1 and 2 reach the count registers of channels 0, 1 and 2. A control byte programs one channel at a time. It sets how count bytes are moved (low only, high only, or low then high), the channel's mode, and whether the channel counts in binary or in four BCD decades. A control byte can also freeze a snapshot of a running count so that it can be read without tearing.

Each channel has its own count clock, its own gate and its own output. The count clock and the gate are synchronised into the system clock domain, and the channel acts on their edges. Two modes are supported:

- **Interrupt on terminal count.** The output goes high once the count reaches zero.
- **Retriggerable one-shot.** Each rising gate edge starts a low pulse that lasts the full programmed count.

Mode codes other than 001 behave as interrupt on terminal count.

Top module: `pit_timer`

## Requirements
- R1: After reset every channel output is low.
- R2: A write at address 3 is a control byte. Bits 7:6 pick the channel, bits 5:4 the byte format, bits 3:1 the mode (000 = interrupt on terminal count, 001 = one-shot) and bit 0 the counting base (1 = BCD, 0 = binary). Addresses 0, 1 and 2 reach the count registers of channels 0, 1 and 2.
- R3: A control byte whose channel field is 11 changes no channel: not its outputs, its count, its format or its mode.
- R4: A newly written count enters the counter only at the first falling edge of the channel clock that follows a rising edge, both occurring after the last required byte was written. Until then the counter holds its previous value.
- R5: In mode 000 the output goes low when the control byte is written and again when a count write completes. Each falling edge of the channel clock decrements the counter. The decrement from 1 to 0 drives the output high, and it stays high while the counter keeps wrapping downward.
- R6: In mode 000 with the low-then-high format, writing the low byte stops the counter. Writing the high byte arms the new count, which is then loaded as in R4.
- R7: In mode 001 the output goes high when the control byte is written. At the first falling edge of the channel clock after a rising edge that sees the gate rise, the output goes low and the count is loaded. After N further falling edges the output returns high.
- R8: In mode 001 a new rising gate edge during the pulse reloads the full count, which stretches the low pulse.
- R9: In mode 001 a count written while the output is low does not change the current pulse. It is used from the next trigger on.
- R10: In BCD mode the counter steps down through four decimal digits and wraps from 0000 to 9999. In binary mode it wraps from 0000 to FFFF.
- R11: A count of zero gives the longest period: 65536 steps in binary, 10000 in BCD.
- R12: Byte format 01 moves only the low byte and format 10 only the high byte; the other byte of a written count is zero. Format 11 alternates low then high, using one byte-order flag per channel shared by reads and writes.
- R13: Format 00 latches the current count for reading. Later latch commands are ignored until the latched value has been fully read, while the counter keeps running underneath.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low, one clk cycle per byte |
| wr_n | input | 1 | Write strobe, active low, one clk cycle per byte |
| addr | input | 2 | Register address (0..2 channels, 3 control) |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, zero when no read is active |
| ch_clk | input | N_CH | Per-channel count clocks |
| ch_gate | input | N_CH | Per-channel gate inputs |
| ch_out | output | N_CH | Per-channel timer outputs |

## Verification
The assertions check the following on every cycle:

- A control byte sets the output level for the selected mode.
- A pending load takes the held count on the falling count-clock edge.
- The terminal-count decrement raises the output.
- A one-shot trigger drops the output and reloads the count.
- The first of two bytes stops the counter.
- A latched snapshot stays frozen.

Several behaviours depend on a sequence of bus and clock activity, and only the bench scenarios can show them. These are the deferred reload during a one-shot pulse, the stretched pulse on retrigger, the illegal channel select, BCD and zero-count wrap, and the byte ordering of reads across formats.

// File: rtl/pit_pkg.sv
`timescale 1ns/1ps
package pit_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int DIGITS = CNT_W / 4;

  localparam logic [1:0] FMT_LATCH = 2'b00;
  localparam logic [1:0] FMT_LO    = 2'b01;
  localparam logic [1:0] FMT_HI    = 2'b10;
  localparam logic [1:0] FMT_BOTH  = 2'b11;

  localparam logic [2:0] MODE_ONESHOT = 3'b001;

  typedef enum logic [1:0] {LD_IDLE, LD_WAIT_RISE, LD_WAIT_FALL} load_st_t;

  // One step down, binary or four BCD decades with borrow.
  function automatic logic [CNT_W-1:0] cnt_dec(input logic [CNT_W-1:0] v,
                                               input logic bcd);
    logic [CNT_W-1:0] r;
    logic borrow;
    r = v;
    borrow = 1'b1;
    if (!bcd) begin
      r = v - CNT_W'(1);
    end else begin
      for (int d = 0; d < DIGITS; d++) begin
        if (borrow) begin
          if (r[d*4 +: 4] == 4'd0) begin
            r[d*4 +: 4] = 4'd9;
          end else begin
            r[d*4 +: 4] = r[d*4 +: 4] - 4'd1;
            borrow = 1'b0;
          end
        end
      end
    end
    return r;
  endfunction

  function automatic logic [BYTE_W-1:0] pick_byte(input logic [CNT_W-1:0] w,
                                                  input logic hi);
    return hi ? w[CNT_W-1:BYTE_W] : w[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/pit_chan_sync.sv
`timescale 1ns/1ps
module pit_chan_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ch_clk,
  input  logic gate,
  output logic clk_rise,
  output logic clk_fall,
  output logic gate_trig
);
  logic clk_s, gate_sync, clk_q, gate_s;

  generate
    if (SYNC_STAGES <= 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          clk_s     <= 1'b0;
          gate_sync <= 1'b0;
        end else begin
          clk_s     <= ch_clk;
          gate_sync <= gate;
        end
      end
    end else begin : g_chain
      logic [SYNC_STAGES-1:0] clk_sh, gate_sh;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          clk_sh  <= '0;
          gate_sh <= '0;
        end else begin
          clk_sh  <= {clk_sh[SYNC_STAGES-2:0], ch_clk};
          gate_sh <= {gate_sh[SYNC_STAGES-2:0], gate};
        end
      end
      assign clk_s     = clk_sh[SYNC_STAGES-1];
      assign gate_sync = gate_sh[SYNC_STAGES-1];
    end
  endgenerate

  // Gate level as seen at the previous rising edge of the count clock.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_q  <= 1'b0;
      gate_s <= 1'b0;
    end else begin
      clk_q <= clk_s;
      if (clk_rise) gate_s <= gate_sync;
    end
  end

  assign clk_rise  = clk_s & ~clk_q;
  assign clk_fall  = ~clk_s & clk_q;
  assign gate_trig = clk_rise & gate_sync & ~gate_s;
endmodule

// File: rtl/pit_channel.sv
`timescale 1ns/1ps
module pit_channel
  import pit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cw_wr,
  input  logic [5:0]        cw_data,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              clk_rise,
  input  logic              clk_fall,
  input  logic              gate_trig,
  output logic [BYTE_W-1:0] rdata,
  output logic              out
);
  logic [1:0]       fmt;
  logic             m1, bcd;
  logic [CNT_W-1:0] cr, ce, ol;
  logic             latched, byte_hi, run, trig_pend, cnt_valid;
  load_st_t         ld;

  // Named events for the assertions.
  logic is_latch, cw_prog, cw_m1, wr_last, first_halt;
  logic load_evt, trig_load, dec_evt, tc_evt;

  assign is_latch   = cw_wr & (cw_data[5:4] == FMT_LATCH);
  assign cw_prog    = cw_wr & ~is_latch;
  assign cw_m1      = (cw_data[3:1] == MODE_ONESHOT);
  assign wr_last    = data_wr & ((fmt != FMT_BOTH) | byte_hi);
  assign first_halt = data_wr & ~m1 & (fmt == FMT_BOTH) & ~byte_hi;
  assign load_evt   = clk_fall & (ld == LD_WAIT_FALL);
  assign trig_load  = clk_fall & ~load_evt & m1 & trig_pend;
  assign dec_evt    = clk_fall & ~load_evt & ~trig_load & run;
  assign tc_evt     = dec_evt & (ce == CNT_W'(1));

  always_comb begin
    case (fmt)
      FMT_HI:   rdata = pick_byte(latched ? ol : ce, 1'b1);
      FMT_BOTH: rdata = pick_byte(latched ? ol : ce, byte_hi);
      default:  rdata = pick_byte(latched ? ol : ce, 1'b0);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt <= FMT_BOTH; m1 <= 1'b0; bcd <= 1'b0;
      cr <= '0; ce <= '0; ol <= '0;
      latched <= 1'b0; byte_hi <= 1'b0; run <= 1'b0;
      trig_pend <= 1'b0; cnt_valid <= 1'b0; ld <= LD_IDLE; out <= 1'b0;
    end else begin
      // count-clock events
      if (load_evt) begin
        ce <= cr; run <= 1'b1; ld <= LD_IDLE;
      end else if (trig_load) begin
        ce <= cr; run <= 1'b1; out <= 1'b0; trig_pend <= 1'b0;
      end else if (dec_evt) begin
        ce <= cnt_dec(ce, bcd);
        if (tc_evt) out <= 1'b1;
      end
      if (clk_rise) begin
        if (ld == LD_WAIT_RISE) ld <= LD_WAIT_FALL;
        if (gate_trig && m1 && cnt_valid) trig_pend <= 1'b1;
      end
      // bus events override the above
      if (cw_prog) begin
        fmt <= cw_data[5:4]; m1 <= cw_m1; bcd <= cw_data[0];
        byte_hi <= 1'b0; latched <= 1'b0; run <= 1'b0;
        trig_pend <= 1'b0; cnt_valid <= 1'b0; ld <= LD_IDLE; out <= cw_m1;
      end else if (is_latch) begin
        if (!latched) begin
          ol <= ce; latched <= 1'b1;
        end
      end else if (data_wr) begin
        case (fmt)
          FMT_LO: cr <= {BYTE_W'(0), wdata};
          FMT_HI: cr <= {wdata, BYTE_W'(0)};
          default: begin
            if (byte_hi) cr[CNT_W-1:BYTE_W] <= wdata;
            else         cr[BYTE_W-1:0]     <= wdata;
          end
        endcase
        if (fmt == FMT_BOTH) byte_hi <= ~byte_hi;
        if (first_halt) run <= 1'b0;
        if (wr_last) begin
          if (m1) cnt_valid <= 1'b1;
          else begin
            ld <= LD_WAIT_RISE; run <= 1'b0; out <= 1'b0;
          end
        end
      end else if (data_rd) begin
        if (fmt == FMT_BOTH) byte_hi <= ~byte_hi;
        if (latched && ((fmt != FMT_BOTH) || byte_hi)) latched <= 1'b0;
      end
    end
  end

  AST_M0_CW_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cw_prog && !cw_m1 |=> !out); // R5
  AST_M1_CW_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cw_prog && cw_m1 |=> out); // R7
  AST_LOAD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt && !cw_prog && !data_wr |=> (ce == $past(cr)) && run); // R4
  AST_TC_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    tc_evt && !cw_prog && !wr_last |=> out); // R5
  AST_TRIG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_load && !cw_prog |=> !out && (ce == $past(cr))); // R8
  AST_FIRST_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    first_halt |=> !run); // R6
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    latched |=> $stable(ol)); // R13
endmodule

// File: rtl/pit_timer.sv
`timescale 1ns/1ps
module pit_timer
  import pit_pkg::*;
#(
  parameter int N_CH        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] dout,
  input  logic [N_CH-1:0]   ch_clk,
  input  logic [N_CH-1:0]   ch_gate,
  output logic [N_CH-1:0]   ch_out
);
  localparam int         ADDR_W    = 2;
  localparam logic [1:0] CTRL_ADDR = 2'b11;

  logic bus_wr, bus_rd, ctrl_hit;
  logic [1:0] sel;
  logic [N_CH-1:0] cw_wr, data_wr, data_rd, c_rise, c_fall, g_trig;
  logic [BYTE_W-1:0] ch_rdata [N_CH];

  assign bus_wr   = ~cs_n & ~wr_n;
  assign bus_rd   = ~cs_n & ~rd_n & ~bus_wr;
  assign ctrl_hit = bus_wr & (addr == CTRL_ADDR);
  assign sel      = din[7:6];

  genvar i;
  generate
    for (i = 0; i < N_CH; i++) begin : g_ch
      assign cw_wr[i]   = ctrl_hit & (sel == ADDR_W'(i));
      assign data_wr[i] = bus_wr & (addr == ADDR_W'(i));
      assign data_rd[i] = bus_rd & (addr == ADDR_W'(i));

      pit_chan_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .ch_clk(ch_clk[i]), .gate(ch_gate[i]),
        .clk_rise(c_rise[i]), .clk_fall(c_fall[i]), .gate_trig(g_trig[i]));

      pit_channel chan_i (
        .clk(clk), .rst_n(rst_n), .cw_wr(cw_wr[i]), .cw_data(din[5:0]),
        .data_wr(data_wr[i]), .data_rd(data_rd[i]), .wdata(din),
        .clk_rise(c_rise[i]), .clk_fall(c_fall[i]), .gate_trig(g_trig[i]),
        .rdata(ch_rdata[i]), .out(ch_out[i]));
    end
  endgenerate

  always_comb begin
    dout = '0;
    for (int k = 0; k < N_CH; k++) begin
      if (bus_rd && (addr == ADDR_W'(k))) dout = ch_rdata[k];
    end
  end

  AST_ONE_CW_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cw_wr)); // R3
endmodule

// File: tb/pit_timer_tb_top.sv
`timescale 1ns/1ps
module pit_timer_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic [2:0] ch_clk = '0, ch_gate = '0, ch_out;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  typedef struct { string req; string what; int exp; } exp_t;
  exp_t sb_q[$];
  int obs_val;
  event obs_ev;

  always #2.5 clk = ~clk;

  pit_timer dut_i (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n),
    .wr_n(wr_n), .addr(addr), .din(din), .dout(dout), .ch_clk(ch_clk),
    .ch_gate(ch_gate), .ch_out(ch_out));

  // monitor: pops expected items and compares with observations
  initial forever begin
    @(obs_ev);
    n_tests++;
    if (sb_q.size() == 0) begin
      n_fail++;
      $display("FAIL unexpected observation act=%0h exp=none", obs_val);
    end else begin
      exp_t e;
      e = sb_q.pop_front();
      if (obs_val != e.exp) begin
        n_fail++;
        $display("FAIL %s %s act=%0h exp=%0h", e.req, e.what, obs_val, e.exp);
      end
    end
  end

  task automatic push_exp(string req, string what, int exp);
    exp_t e;
    e.req = req; e.what = what; e.exp = exp;
    sb_q.push_back(e);
  endtask

  task automatic observe(int v);
    obs_val = v;
    ->obs_ev;
    #0.1;
  endtask

  task automatic bus_write(logic [1:0] a, logic [7:0] d);
    @(posedge clk); #1;
    cs_n = 0; wr_n = 0; addr = a; din = d;
    @(posedge clk); #1;
    cs_n = 1; wr_n = 1;
  endtask

  task automatic chk_rd(logic [1:0] a, int exp, string req);
    int v;
    @(posedge clk); #1;
    cs_n = 0; rd_n = 0; addr = a;
    push_exp(req, "read byte", exp);
    @(negedge clk);
    v = dout;
    observe(v);
    @(posedge clk); #1;
    cs_n = 1; rd_n = 1;
  endtask

  task automatic chk_out(int ch, int exp, string req);
    @(negedge clk);
    push_exp(req, $sformatf("ch%0d out", ch), exp);
    observe(ch_out[ch]);
  endtask

  task automatic tick(int ch);
    @(posedge clk); #1;
    ch_clk[ch] = 1'b1;
    repeat (4) @(posedge clk);
    #1 ch_clk[ch] = 1'b0;
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic ticks(int ch, int n);
    for (int k = 0; k < n; k++) tick(ch);
  endtask

  // latch then read low, high (format 11)
  task automatic latch_rd(int ch, int exp16, string req);
    bus_write(2'd3, {2'(ch), 6'b000000});
    chk_rd(2'(ch), exp16 & 8'hFF, req);
    chk_rd(2'(ch), (exp16 >> 8) & 8'hFF, req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_run();
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    for (int c = 0; c < 3; c++) chk_out(c, 0, "R1");

    // ch0 mode 000 binary, low-then-high
    bus_write(2'd3, 8'h30);
    chk_out(0, 0, "R2 R5");
    bus_write(2'd0, 8'h05); bus_write(2'd0, 8'h00);
    tick(0);                       // load 5
    ticks(0, 4);
    chk_out(0, 0, "R5");
    tick(0);
    chk_out(0, 1, "R5");
    ticks(0, 2);
    chk_out(0, 1, "R5");
    latch_rd(0, 16'hFFFE, "R10 R13");

    // load needs rise then fall
    bus_write(2'd0, 8'h03); bus_write(2'd0, 8'h00);
    chk_out(0, 0, "R5");
    @(posedge clk); #1 ch_clk[0] = 1'b1;
    repeat (4) @(posedge clk); #1;
    latch_rd(0, 16'hFFFE, "R4");
    ch_clk[0] = 1'b0;
    repeat (4) @(posedge clk); #1;
    latch_rd(0, 16'h0003, "R4");

    // first byte halts counting
    ticks(0, 2);                   // ce = 1
    bus_write(2'd0, 8'h04);
    ticks(0, 3);
    chk_out(0, 0, "R6");
    bus_write(2'd0, 8'h00);
    tick(0);                       // load 4
    ticks(0, 3);
    chk_out(0, 0, "R6");
    tick(0);
    chk_out(0, 1, "R6");

    // latch freeze
    bus_write(2'd3, 8'h30);
    bus_write(2'd0, 8'h05); bus_write(2'd0, 8'h01);
    tick(0);
    bus_write(2'd3, 8'h00);
    ticks(0, 3);
    bus_write(2'd3, 8'h00);        // ignored while latched
    chk_rd(2'd0, 8'h05, "R13");
    chk_rd(2'd0, 8'h01, "R13");
    latch_rd(0, 16'h0102, "R13");

    // ch1 BCD
    bus_write(2'd3, 8'h71);
    bus_write(2'd1, 8'h10); bus_write(2'd1, 8'h00);
    tick(1); tick(1);
    latch_rd(1, 16'h0009, "R10");
    bus_write(2'd1, 8'h00); bus_write(2'd1, 8'h00);
    tick(1); tick(1);
    latch_rd(1, 16'h9999, "R11");
    tick(1);
    latch_rd(1, 16'h9998, "R10");

    // ch2 binary zero count
    bus_write(2'd3, 8'hB0);
    bus_write(2'd2, 8'h00); bus_write(2'd2, 8'h00);
    tick(2); tick(2);
    latch_rd(2, 16'hFFFF, "R11");

    // single-byte formats
    bus_write(2'd3, 8'h90);
    bus_write(2'd2, 8'h07);
    tick(2);
    chk_rd(2'd2, 8'h07, "R2 R12");
    tick(2);
    chk_rd(2'd2, 8'h06, "R12");
    bus_write(2'd3, 8'hA0);
    bus_write(2'd2, 8'h02);
    tick(2);
    chk_rd(2'd2, 8'h02, "R12");
    tick(2);
    chk_rd(2'd2, 8'h01, "R12");

    // illegal channel select
    bus_write(2'd3, 8'hF2);
    bus_write(2'd3, 8'hC0);
    for (int c = 0; c < 3; c++) chk_out(c, 0, "R3");
    latch_rd(0, 16'h0102, "R3");
    tick(0);
    latch_rd(0, 16'h0101, "R3");

    // ch1 mode 001 one-shot
    bus_write(2'd3, 8'h72);
    chk_out(1, 1, "R7");
    bus_write(2'd1, 8'h03); bus_write(2'd1, 8'h00);
    ticks(1, 2);
    chk_out(1, 1, "R7");
    ch_gate[1] = 1'b1;
    tick(1);
    chk_out(1, 0, "R7");
    ticks(1, 2);
    chk_out(1, 0, "R7");
    tick(1);
    chk_out(1, 1, "R7");

    // retrigger stretches the pulse
    ch_gate[1] = 1'b0; tick(1);
    ch_gate[1] = 1'b1; tick(1);    // ce = 3
    tick(1);                       // ce = 2
    ch_gate[1] = 1'b0; tick(1);    // ce = 1
    ch_gate[1] = 1'b1; tick(1);    // retrigger, ce = 3
    chk_out(1, 0, "R8");
    ticks(1, 2);
    chk_out(1, 0, "R8");
    tick(1);
    chk_out(1, 1, "R8");

    // reload during pulse is deferred
    ch_gate[1] = 1'b0; tick(1);
    ch_gate[1] = 1'b1; tick(1);    // ce = 3
    bus_write(2'd1, 8'h05); bus_write(2'd1, 8'h00);
    ticks(1, 2);
    chk_out(1, 0, "R9");
    tick(1);
    chk_out(1, 1, "R9");
    ch_gate[1] = 1'b0; tick(1);
    ch_gate[1] = 1'b1; tick(1);    // ce = 5
    ticks(1, 4);
    chk_out(1, 0, "R9");
    tick(1);
    chk_out(1, 1, "R9");

    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule